// File: doc/BRIEF.md
# Energy-Detect Power-Down Controller

This block gates the power domain of a network physical-layer datapath when the line is quiet. A configuration bit arms the mode. While the mode is armed and the synchronised energy-detect input is low, the block saves the live datapath state, isolates the datapath outputs, removes datapath power and blocks transmission. The management interface, squelch and energy-detect logic stay in the always-on domain. The block itself sits in that domain, so it keeps tracking line energy during power-down.

Line energy of any kind (link pulses, packets, auto-negotiation bursts) arrives on one asynchronous input. The block passes it through a two-flop synchroniser. When energy returns, the block restores power and waits a fixed power-good interval with isolation still applied. It then releases isolation and presents the saved state for one reload cycle, and only after that does it re-enable transmit. Each energy wake-up sets a sticky flag, which the host clears by writing one. A maskable host interrupt follows the flag. The packet or two that cause the wake-up may be lost, and nothing here tries to capture them.

Top module: `epd_power_ctrl`

## Requirements
- R1: After reset, power is on (`dpPowerOn`=1), isolation is off, transmit is enabled, and `energyFlag` and `hostIrq` are 0.
- R2: `energyDetected` follows `energyAsync` two clock edges later. This tracking continues while the datapath is powered down.
- R3: With `modeEn`=1 and `energyDetected`=0 in the run state, the next edge drives `dpPowerOn`=0, `dpIsolate`=1 and `txEnable`=0. Whenever power is off, transmit is off and isolation is on.
- R4: While `modeEn`=0 the block never removes power, whatever the energy input does.
- R5: Clearing `modeEn` while powered down starts the power-up sequence without setting `energyFlag`.
- R6: With `modeEn`=1 and `energyDetected`=1 while powered down, the next edge restores power. Isolation stays on and transmit stays off for `PG_CYCLES` cycles.
- R7: After the power-good interval comes exactly one reload cycle. In it, `dpIsolate`=0, `stateLoad`=1, `txEnable`=0, and `stateOut` equals the `stateIn` value sampled on the edge that entered power-down. Transmit is enabled on the following cycle.
- R8: An energy wake-up sets `energyFlag`, and the flag stays set until a clear.
- R9: `flagClear`=1 clears `energyFlag` on the next edge. A wake-up on that same edge takes priority, so the flag ends up set.
- R10: `hostIrq` is 1 exactly when `energyFlag`=1 and `intEnable`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeEn | input | 1 | Arms energy-driven power-down |
| energyAsync | input | 1 | Raw line-energy indication, asynchronous |
| intEnable | input | 1 | Enables the host interrupt for the energy-on flag |
| flagClear | input | 1 | Write-one-to-clear strobe for the energy-on flag |
| stateIn | input | STATE_W | Live datapath state to be saved |
| energyDetected | output | 1 | Synchronised energy indication |
| dpPowerOn | output | 1 | Datapath power-switch enable |
| dpIsolate | output | 1 | Datapath output isolation |
| txEnable | output | 1 | Transmit permitted |
| stateLoad | output | 1 | Reload strobe for the datapath state |
| stateOut | output | STATE_W | Saved state presented for reload |
| energyFlag | output | 1 | Sticky energy-on interrupt source |
| hostIrq | output | 1 | Masked host interrupt |

## Verification
The bench targets a wake-up that lands on the same edge as a host clear. A design that gives the clear priority loses the event, so the flag never appears. It also drops the mode bit while powered down: a design that treats that exit as a wake-up raises a false interrupt, and one that ignores it stays dark. The saved state is checked against a `stateIn` that changes every cycle, which catches a capture one cycle early or late. The power-good and reload cycles are timed edge by edge, which exposes a transmit enable that comes before the reload, or an isolation release made too soon.

// File: rtl/epd_pkg.sv
package epd_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DOWN = 2'd1,
    ST_WAKE = 2'd2,
    ST_LOAD = 2'd3
  } pdState_t;

  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic saveState;
    logic loadState;
    logic wakeEvent;
  } pdStrobe_t;
endpackage

// File: rtl/epd_control.sv
module epd_control
  import epd_pkg::*;
#(
  parameter int PG_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeEn,
  input  logic      energyOn,
  output pdStrobe_t strobes,
  output logic      dpPowerOn,
  output logic      dpIsolate,
  output logic      txEnable
);
  localparam int CW = (PG_CYCLES > 1) ? $clog2(PG_CYCLES) : 1;
  localparam logic [CW-1:0] PG_LAST = CW'(PG_CYCLES - 1);

  pdState_t state, stateNext;
  logic [CW-1:0] pgCount;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_RUN: begin
        if (modeEn && !energyOn) begin
          strobes.saveState = 1'b1;
          stateNext         = ST_DOWN;
        end
      end
      ST_DOWN: begin
        if (!modeEn) begin
          stateNext = ST_WAKE;
        end else if (energyOn) begin
          strobes.wakeEvent = 1'b1;
          stateNext         = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (pgCount == PG_LAST) stateNext = ST_LOAD;
      end
      ST_LOAD: begin
        strobes.loadState = 1'b1;
        stateNext         = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      pgCount <= '0;
    end else begin
      state <= stateNext;
      if (state != ST_WAKE) pgCount <= '0;
      else if (pgCount != PG_LAST) pgCount <= pgCount + 1'b1;
    end
  end

  assign dpPowerOn = (state != ST_DOWN);
  assign dpIsolate = (state == ST_DOWN) || (state == ST_WAKE);
  assign txEnable  = (state == ST_RUN);
endmodule

// File: rtl/epd_datapath.sv
module epd_datapath
  import epd_pkg::*;
#(
  parameter int STATE_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               energyAsync,
  input  logic [STATE_W-1:0] stateIn,
  input  pdStrobe_t          strobes,
  input  logic               flagClear,
  input  logic               intEnable,
  output logic               energyOn,
  output logic [STATE_W-1:0] stateOut,
  output logic               stateLoad,
  output logic               energyFlag,
  output logic               hostIrq
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic [STATE_W-1:0]     savedState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], energyAsync};
  end
  assign energyOn = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  savedState <= '0;
    else if (strobes.saveState) savedState <= stateIn;
  end

  // A wake-up on the same edge as a clear keeps the flag set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  energyFlag <= 1'b0;
    else if (strobes.wakeEvent) energyFlag <= 1'b1;
    else if (flagClear)         energyFlag <= 1'b0;
  end

  assign stateOut  = savedState;
  assign stateLoad = strobes.loadState;
  assign hostIrq   = energyFlag & intEnable;
endmodule

// File: rtl/epd_power_ctrl.sv
module epd_power_ctrl
  import epd_pkg::*;
#(
  parameter int STATE_W   = 8,
  parameter int PG_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeEn,
  input  logic               energyAsync,
  input  logic               intEnable,
  input  logic               flagClear,
  input  logic [STATE_W-1:0] stateIn,
  output logic               energyDetected,
  output logic               dpPowerOn,
  output logic               dpIsolate,
  output logic               txEnable,
  output logic               stateLoad,
  output logic [STATE_W-1:0] stateOut,
  output logic               energyFlag,
  output logic               hostIrq
);
  pdStrobe_t strobes;

  epd_control #(.PG_CYCLES(PG_CYCLES)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .modeEn    (modeEn),
    .energyOn  (energyDetected),
    .strobes   (strobes),
    .dpPowerOn (dpPowerOn),
    .dpIsolate (dpIsolate),
    .txEnable  (txEnable)
  );

  epd_datapath #(.STATE_W(STATE_W), .SYNC_STAGES(2)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .energyAsync (energyAsync),
    .stateIn     (stateIn),
    .strobes     (strobes),
    .flagClear   (flagClear),
    .intEnable   (intEnable),
    .energyOn    (energyDetected),
    .stateOut    (stateOut),
    .stateLoad   (stateLoad),
    .energyFlag  (energyFlag),
    .hostIrq     (hostIrq)
  );
endmodule

// File: rtl/epd_power_ctrl_chk.sv
module epd_power_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic modeEn,
  input logic intEnable,
  input logic flagClear,
  input logic dpPowerOn,
  input logic dpIsolate,
  input logic txEnable,
  input logic stateLoad,
  input logic energyFlag,
  input logic hostIrq
);
  p_off_blocks_tx_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dpPowerOn |-> (!txEnable && dpIsolate));

  p_mode_off_stays_on_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!modeEn && dpPowerOn) |=> dpPowerOn);

  p_load_conditions_r7: assert property (@(posedge clk) disable iff (!rstN)
    stateLoad |-> (dpPowerOn && !dpIsolate && !txEnable));

  p_load_then_tx_r7: assert property (@(posedge clk) disable iff (!rstN)
    stateLoad |=> (txEnable && !stateLoad));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (energyFlag && !flagClear) |=> energyFlag);

  p_masked_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> !hostIrq);

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> energyFlag);
endmodule

bind epd_power_ctrl epd_power_ctrl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeEn     (modeEn),
  .intEnable  (intEnable),
  .flagClear  (flagClear),
  .dpPowerOn  (dpPowerOn),
  .dpIsolate  (dpIsolate),
  .txEnable   (txEnable),
  .stateLoad  (stateLoad),
  .energyFlag (energyFlag),
  .hostIrq    (hostIrq)
);

// File: tb/epd_power_ctrl_bench.sv
`timescale 1ns/1ps
module epd_power_ctrl_bench;
  localparam int SW = 8;
  localparam int PG = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeEn = 1'b0, energyAsync = 1'b0, intEnable = 1'b0, flagClear = 1'b0;
  logic [SW-1:0] stateIn = '0;
  logic energyDetected, dpPowerOn, dpIsolate, txEnable, stateLoad, energyFlag, hostIrq;
  logic [SW-1:0] stateOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  epd_power_ctrl #(.STATE_W(SW), .PG_CYCLES(PG)) u_epd_power_ctrl (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .energyAsync(energyAsync),
    .intEnable(intEnable), .flagClear(flagClear), .stateIn(stateIn),
    .energyDetected(energyDetected), .dpPowerOn(dpPowerOn), .dpIsolate(dpIsolate),
    .txEnable(txEnable), .stateLoad(stateLoad), .stateOut(stateOut),
    .energyFlag(energyFlag), .hostIrq(hostIrq)
  );

  // Behavioural reference model: mode 0=run 1=down 2=waiting power-good 3=reload
  int mMode = 0;
  int mCount = 0;
  bit mE1 = 0, mE2 = 0, mFlag = 0;
  int mSaved = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mCount = 0; mE1 = 0; mE2 = 0; mFlag = 0; mSaved = 0;
    end else begin
      bit wake;
      wake = 0;
      if (mMode == 0) begin
        if (modeEn && !mE2) begin mSaved = int'(stateIn); mMode = 1; end
      end else if (mMode == 1) begin
        if (!modeEn) begin mMode = 2; mCount = 0; end
        else if (mE2) begin wake = 1; mMode = 2; mCount = 0; end
      end else if (mMode == 2) begin
        mCount++;
        if (mCount == PG) mMode = 3;
      end else begin
        mMode = 0;
      end
      if (wake) mFlag = 1;
      else if (flagClear) mFlag = 0;
      mE2 = mE1;
      mE1 = energyAsync;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk("R2 energyDetected", int'(energyDetected), int'(mE2));
      chk("R3 dpPowerOn", int'(dpPowerOn), int'(mMode != 1));
      chk("R6 dpIsolate", int'(dpIsolate), int'(mMode == 1 || mMode == 2));
      chk("R7 txEnable", int'(txEnable), int'(mMode == 0));
      chk("R7 stateLoad", int'(stateLoad), int'(mMode == 3));
      if (mMode == 3) chk("R7 stateOut", int'(stateOut), mSaved);
      chk("R8 energyFlag", int'(energyFlag), int'(mFlag));
      chk("R10 hostIrq", int'(hostIrq), int'(mFlag && intEnable));
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Inputs change just after the falling edge
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      stateIn = stateIn + 8'd37;
    end
  endtask

  int pulses;

  initial begin
    step(4);
    chk("R1 reset dpPowerOn", int'(dpPowerOn), 1);
    chk("R1 reset dpIsolate", int'(dpIsolate), 0);
    chk("R1 reset txEnable", int'(txEnable), 1);
    chk("R1 reset energyFlag", int'(energyFlag), 0);
    chk("R1 reset hostIrq", int'(hostIrq), 0);
    rstN = 1'b1;
    step(2);

    // R4: mode disabled, quiet line, power stays on
    step(12);
    chk("R4 mode off keeps power", int'(dpPowerOn), 1);

    // R3: arm mode with quiet line
    modeEn = 1'b1; intEnable = 1'b1;
    step(6);
    chk("R3 powered down", int'(dpPowerOn), 0);
    chk("R3 tx blocked", int'(txEnable), 0);

    // R2: energy tracked while down, then wake (R6, R7, R8, R10)
    energyAsync = 1'b1;
    step(1);
    chk("R2 not yet synced", int'(energyDetected), 0);
    step(1);
    chk("R2 synced", int'(energyDetected), 1);
    step(PG + 4);
    chk("R8 flag after wake", int'(energyFlag), 1);
    chk("R10 irq after wake", int'(hostIrq), 1);
    chk("R7 tx back on", int'(txEnable), 1);
    step(5);
    chk("R8 flag sticky", int'(energyFlag), 1);

    // R9: plain clear
    flagClear = 1'b1; step(1); flagClear = 1'b0; step(1);
    chk("R9 flag cleared", int'(energyFlag), 0);

    // R9: clear held across a wake-up; flag must be seen for exactly one cycle
    energyAsync = 1'b0;
    step(6);
    flagClear = 1'b1;
    energyAsync = 1'b1;
    pulses = 0;
    for (int i = 0; i < PG + 8; i++) begin
      step(1);
      if (energyFlag) pulses++;
    end
    flagClear = 1'b0;
    chk("R9 wake beats clear", pulses, 1);

    // R5: mode cleared while down, no flag
    energyAsync = 1'b0;
    step(6);
    chk("R5 down before exit", int'(dpPowerOn), 0);
    modeEn = 1'b0;
    step(PG + 4);
    chk("R5 powered up", int'(txEnable), 1);
    chk("R5 no flag", int'(energyFlag), 0);

    // R10: masked wake-up
    intEnable = 1'b0; modeEn = 1'b1;
    step(6);
    energyAsync = 1'b1;
    step(PG + 6);
    chk("R10 flag set masked", int'(energyFlag), 1);
    chk("R10 irq masked", int'(hostIrq), 0);
    intEnable = 1'b1;
    step(1);
    chk("R10 irq unmasked", int'(hostIrq), 1);

    // R4: drop mode, then quiet line, stays up
    modeEn = 1'b0; energyAsync = 1'b0;
    step(10);
    chk("R4 no power-down with mode off", int'(dpPowerOn), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule